// File: doc/BRIEF.md
# External DMA Handshake Controller

A single-channel DMA engine that moves words one at a time when an outside device asks for them. The device pulls an active-low request line; the channel answers each falling edge of that line with exactly one word transfer, marked by an active-low grant strobe and/or external read and write strobes. The movement follows one of three handshake modes. In plain handshake the grant alone marks the word that moves between the device and internal memory. In external handshake a device and external memory exchange the word under the channel's address and strobes. In paced master the channel runs the external bus itself with no grant and moves the word between external and internal memory.

Software loads an internal address, an external address, a word count, a control word and a link pointer, then starts the channel. When the count runs out, the channel either fetches a four-word descriptor from internal memory and keeps going, or stops and raises a one-cycle interrupt. External accesses stretch for as long as the acknowledge input is held low.

Top module: `xdma_chan`

## Requirements
- R1: After reset, `dmag_n`, `ext_rd_n` and `ext_wr_n` are high, and `irq` and `mem_we` are low.
- R2: `dmar_n` passes through a two-flop synchronizer. Each falling edge of it yields exactly one word transfer, however long the line stays low. Edges that arrive while the channel is idle are discarded.
- R3: Plain handshake mode is control bits [1:0] = 0, and the reserved value 3 behaves the same way. Each word drives `dmag_n` low for exactly one clock and ignores `ext_ack`. With control bit 2 = 0, `ext_din` is written to internal memory at the internal address in that clock. With bit 2 = 1, the internal word at that address appears on `ext_dout`. Only the internal address steps.
- R4: In external handshake mode (control bits [1:0] = 1), `dmag_n` is driven low together with `ext_wr_n` (bit 2 = 0) or `ext_rd_n` (bit 2 = 1) at the external address. Internal memory is never written, and only the external address steps.
- R5: In paced master mode (control bits [1:0] = 2), `dmag_n` stays high. With bit 2 = 0, `ext_rd_n` reads `ext_din` into internal memory. With bit 2 = 1, `ext_wr_n` sends the internal word on `ext_dout`. Both addresses step.
- R6: In external handshake and paced master modes, grant, strobes and address hold while `ext_ack` is low. The word completes in the clock where `ext_ack` is high, so a word with N wait cycles keeps its strobe low for N+1 clocks.
- R7: The count drops by one per word. When it reaches zero with a zero link pointer, `irq` pulses high for one clock and the channel stops answering requests.
- R8: When the count reaches zero with a nonzero link pointer L, the channel reads internal words L, L+1, L+2 and L+3 as the new internal address, external address, count and link pointer. It then continues in the same mode without an interrupt.
- R9: Register writes (`cfg_sel` 0 internal address, 1 external address, 2 count, 3 control, 4 link) take effect only while the channel is idle, which is from reset or the interrupt until `cfg_go`.
- R10: Starting with a zero count and a zero link pointer raises `irq` without any transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | AW | Register write value |
| cfg_go | input | 1 | Start the channel |
| dmar_n | input | 1 | Active-low transfer request (asynchronous) |
| dmag_n | output | 1 | Active-low grant strobe |
| ext_addr | output | AW | External address |
| ext_rd_n | output | 1 | Active-low external read strobe |
| ext_wr_n | output | 1 | Active-low external write strobe |
| ext_ack | input | 1 | External acknowledge, low inserts wait states |
| ext_din | input | DW | Data arriving from outside |
| ext_dout | output | DW | Data leaving internal memory |
| mem_addr | output | AW | Internal memory address |
| mem_we | output | 1 | Internal memory write enable |
| mem_wdata | output | DW | Internal memory write data |
| mem_rdata | input | DW | Internal memory read data, same cycle |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a descriptor fetch that sits between words of one block. The stimulus starts a block of one word whose link points at a descriptor placed in the bench memory, then keeps issuing requests. It expects three words from two address ranges and a single interrupt at the very end. A scoreboard also catches a long-held request that would produce a second word, and reprogramming attempts made mid-block that would move the address or lengthen the block.

// File: rtl/xdma_pkg.sv
package xdma_pkg;

    typedef enum logic [1:0] {
        HM_PLAIN  = 2'd0,
        HM_EXTMEM = 2'd1,
        HM_PACED  = 2'd2
    } hmode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NEXT,
        ST_ARM,
        ST_XFER,
        ST_LOAD
    } st_e;

    typedef struct packed {
        logic   outward;
        hmode_e mode;
    } ctl_t;

    typedef struct packed {
        logic grant_n;
        logic rd_n;
        logic wr_n;
        logic done;
        logic mem_wr;
        logic step_int;
        logic step_ext;
    } pins_t;

    localparam logic [2:0] SEL_IADDR = 3'd0;
    localparam logic [2:0] SEL_EADDR = 3'd1;
    localparam logic [2:0] SEL_COUNT = 3'd2;
    localparam logic [2:0] SEL_CTL   = 3'd3;
    localparam logic [2:0] SEL_LINK  = 3'd4;

    localparam int DESC_WORDS = 4;

    function automatic ctl_t decode_ctl(input logic [2:0] v);
        ctl_t c;
        c.outward = v[2];
        case (v[1:0])
            2'd1:    c.mode = HM_EXTMEM;
            2'd2:    c.mode = HM_PACED;
            default: c.mode = HM_PLAIN;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/xdma_reqsync.sv
module xdma_reqsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_n,
    input  logic flush,
    input  logic take,
    output logic pend
);
    localparam int SW = STAGES + 1;

    logic [SW-1:0] sh;
    logic          fall;

    generate
        for (genvar i = 0; i < SW; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sh[i] <= 1'b1;
                    else     sh[i] <= req_n;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) sh[i] <= 1'b1;
                    else     sh[i] <= sh[i-1];
                end
            end
        end
    endgenerate

    assign fall = sh[STAGES] & ~sh[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst || flush)  pend <= 1'b0;
        else if (fall)     pend <= 1'b1;
        else if (take)     pend <= 1'b0;
    end

    assert_take_needs_pend_R2: assert property (@(posedge clk) disable iff (rst)
        take |-> pend);

    assert_edge_registers_R2: assert property (@(posedge clk) disable iff (rst)
        (fall && !flush) |=> pend);

endmodule

// File: rtl/xdma_strobe.sv
module xdma_strobe
    import xdma_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  ctl_t  ctl,
    input  logic  ack,
    output pins_t pins
);
    always_comb begin
        pins = '{grant_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, done: 1'b0,
                 mem_wr: 1'b0, step_int: 1'b0, step_ext: 1'b0};
        if (active) begin
            case (ctl.mode)
                HM_EXTMEM: begin
                    pins.grant_n  = 1'b0;
                    pins.rd_n     = ~ctl.outward;
                    pins.wr_n     = ctl.outward;
                    pins.done     = ack;
                    pins.step_ext = 1'b1;
                end
                HM_PACED: begin
                    pins.rd_n     = ctl.outward;
                    pins.wr_n     = ~ctl.outward;
                    pins.done     = ack;
                    pins.mem_wr   = ~ctl.outward & ack;
                    pins.step_int = 1'b1;
                    pins.step_ext = 1'b1;
                end
                default: begin
                    pins.grant_n  = 1'b0;
                    pins.done     = 1'b1;
                    pins.mem_wr   = ~ctl.outward;
                    pins.step_int = 1'b1;
                end
            endcase
        end
    end

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        !(!pins.rd_n && !pins.wr_n));

endmodule

// File: rtl/xdma_engine.sv
module xdma_engine
    import xdma_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          cfg_go,
    input  logic          pend,
    input  pins_t         pins,
    input  logic [AW-1:0] rd_word,
    output logic          take,
    output logic          flush,
    output logic          active,
    output ctl_t          ctl,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] ext_addr,
    output logic          irq
);
    localparam int LIW = $clog2(DESC_WORDS);
    localparam logic [LIW-1:0] LAST_IDX = LIW'(DESC_WORDS - 1);

    st_e           st;
    logic [AW-1:0] iptr, eptr, cnt, link;
    logic [LIW-1:0] lidx;
    logic          irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            iptr  <= '0;
            eptr  <= '0;
            cnt   <= '0;
            link  <= '0;
            ctl   <= decode_ctl(3'd0);
            lidx  <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (st == ST_IDLE && cfg_we) begin
                case (cfg_sel)
                    SEL_IADDR: iptr <= cfg_wdata;
                    SEL_EADDR: eptr <= cfg_wdata;
                    SEL_COUNT: cnt  <= cfg_wdata;
                    SEL_CTL:   ctl  <= decode_ctl(cfg_wdata[2:0]);
                    SEL_LINK:  link <= cfg_wdata;
                    default: ;
                endcase
            end
            case (st)
                ST_IDLE: if (cfg_go) st <= ST_NEXT;
                ST_NEXT: begin
                    if (cnt != '0) begin
                        st <= ST_ARM;
                    end else if (link != '0) begin
                        st   <= ST_LOAD;
                        lidx <= '0;
                    end else begin
                        irq_q <= 1'b1;
                        st    <= ST_IDLE;
                    end
                end
                ST_ARM: if (pend) st <= ST_XFER;
                ST_XFER: begin
                    if (pins.done) begin
                        cnt <= cnt - 1'b1;
                        if (pins.step_int) iptr <= iptr + 1'b1;
                        if (pins.step_ext) eptr <= eptr + 1'b1;
                        st <= ST_NEXT;
                    end
                end
                ST_LOAD: begin
                    case (lidx)
                        LIW'(0): iptr <= rd_word;
                        LIW'(1): eptr <= rd_word;
                        LIW'(2): cnt  <= rd_word;
                        default: link <= rd_word;
                    endcase
                    lidx <= lidx + 1'b1;
                    if (lidx == LAST_IDX) st <= ST_NEXT;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign take     = (st == ST_ARM) && pend;
    assign flush    = (st == ST_IDLE);
    assign active   = (st == ST_XFER);
    assign mem_addr = (st == ST_LOAD) ? link + AW'(lidx) : iptr;
    assign ext_addr = eptr;
    assign irq      = irq_q;

    assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_XFER && pins.done) |=> (cnt == $past(cnt) - 1'b1));

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);

    assert_busy_regs_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ARM) |=> ($stable(iptr) && $stable(link) && $stable(cnt)));

endmodule

// File: rtl/xdma_chan.sv
module xdma_chan
    import xdma_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          cfg_go,
    input  logic          dmar_n,
    output logic          dmag_n,
    output logic [AW-1:0] ext_addr,
    output logic          ext_rd_n,
    output logic          ext_wr_n,
    input  logic          ext_ack,
    input  logic [DW-1:0] ext_din,
    output logic [DW-1:0] ext_dout,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          irq
);
    logic  pend, take, flush, active;
    ctl_t  ctl;
    pins_t pins;

    xdma_reqsync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .req_n (dmar_n),
        .flush (flush),
        .take  (take),
        .pend  (pend)
    );

    xdma_strobe u_strobe (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .ctl    (ctl),
        .ack    (ext_ack),
        .pins   (pins)
    );

    xdma_engine #(.AW(AW)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_go    (cfg_go),
        .pend      (pend),
        .pins      (pins),
        .rd_word   (mem_rdata[AW-1:0]),
        .take      (take),
        .flush     (flush),
        .active    (active),
        .ctl       (ctl),
        .mem_addr  (mem_addr),
        .ext_addr  (ext_addr),
        .irq       (irq)
    );

    assign dmag_n    = pins.grant_n;
    assign ext_rd_n  = pins.rd_n;
    assign ext_wr_n  = pins.wr_n;
    assign mem_we    = active & pins.mem_wr;
    assign mem_wdata = ext_din;
    assign ext_dout  = mem_rdata;

    assert_plain_grant_one_clock_R3: assert property (@(posedge clk) disable iff (rst)
        (!dmag_n && ext_rd_n && ext_wr_n) |=> dmag_n);

    assert_hold_in_wait_R6: assert property (@(posedge clk) disable iff (rst)
        ((!ext_rd_n || !ext_wr_n) && !ext_ack) |=>
            ((!ext_rd_n || !ext_wr_n) && $stable(ext_addr) && $stable(dmag_n)));

    assert_extmem_no_internal_write_R4: assert property (@(posedge clk) disable iff (rst)
        (!dmag_n && !(ext_rd_n && ext_wr_n)) |-> !mem_we);

endmodule

// File: tb/xdma_chan_bench.sv
module xdma_chan_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 20000;

    localparam logic [3:0] K_GIN = 4'd1, K_GOUT = 4'd2, K_EWR = 4'd3, K_ERD = 4'd4,
                           K_PRD = 4'd5, K_PWR = 4'd6, K_IRQ = 4'd7;

    typedef struct packed {
        logic [3:0]  kind;
        logic [15:0] a;
        logic [15:0] b;
        logic [31:0] d;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0, cfg_go = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        dmar_n = 1'b1;
    logic        dmag_n, ext_rd_n, ext_wr_n, ext_ack, mem_we, irq;
    logic [15:0] ext_addr, mem_addr;
    logic [31:0] ext_din = '0, ext_dout, mem_wdata, mem_rdata;

    logic [31:0] mem [0:63];
    int          waits = 0;
    bit          force_low = 1'b0;
    int          ack_run = 0;
    int          exp_len = 1;
    int          run = 0;
    int          total = 0, fails = 0;
    item_t       exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    xdma_chan u_xdma_chan (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_go(cfg_go), .dmar_n(dmar_n), .dmag_n(dmag_n), .ext_addr(ext_addr),
        .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_ack(ext_ack), .ext_din(ext_din),
        .ext_dout(ext_dout), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .irq(irq)
    );

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'hA000_0000 + i;
        mem[56] = 32'd12;
        mem[57] = 32'h0000_0500;
        mem[58] = 32'd2;
        mem[59] = 32'd0;
    end
    always @(posedge clk) if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
    assign mem_rdata = mem[mem_addr[5:0]];

    assign ext_ack = !force_low && (ack_run >= waits);
    always @(posedge clk)
        ack_run <= ((!ext_rd_n || !ext_wr_n) && !ext_ack) ? ack_run + 1 : 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic push(input logic [3:0] k, input logic [15:0] a, input logic [15:0] b,
                        input logic [31:0] d, input string tag);
        exp_q.push_back('{kind: k, a: a, b: b, d: d});
        tag_q.push_back(tag);
    endtask

    task automatic compare(input item_t got);
        item_t e;
        string t;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected event", {4'd0, got[63:4]}, 64'd0);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(got == e, t, {got.kind, got.a, got.b, got.d[27:0]},
                {e.kind, e.a, e.b, e.d[27:0]});
        end
    endtask

    // monitor: classifies completed words and interrupts seen at the pins
    always @(negedge clk) begin
        item_t g;
        bit    done;
        if (rst) begin
            run = 0;
        end else begin
            run  = (!dmag_n || !ext_rd_n || !ext_wr_n) ? run + 1 : 0;
            done = 1'b0;
            g    = '0;
            if (irq) begin
                g.kind = K_IRQ;
                compare(g);
                g = '0;
            end
            if (!dmag_n && ext_rd_n && ext_wr_n) begin
                done = 1'b1;
                g.kind = mem_we ? K_GIN : K_GOUT;
                g.a = mem_addr;
                g.d = mem_we ? mem_wdata : ext_dout;
            end else if (!dmag_n && ext_ack && (!ext_rd_n || !ext_wr_n)) begin
                done = 1'b1;
                g.kind = !ext_wr_n ? K_EWR : K_ERD;
                g.a = ext_addr;
            end else if (dmag_n && ext_ack && (!ext_rd_n || !ext_wr_n)) begin
                done = 1'b1;
                g.kind = !ext_rd_n ? K_PRD : K_PWR;
                g.a = ext_addr;
                g.b = mem_addr;
                g.d = !ext_rd_n ? mem_wdata : ext_dout;
            end
            if (done) begin
                compare(g);
                chk(run == exp_len, "R6 strobe length", 64'(run), 64'(exp_len));
            end else if (mem_we) begin
                chk(1'b0, "R4 stray internal write", 64'(mem_addr), 64'd0);
            end
        end
    end

    task automatic cfg(input logic [2:0] s, input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input logic [15:0] ia, input logic [15:0] ea, input logic [15:0] n,
                         input logic [15:0] c, input logic [15:0] l);
        cfg(3'd0, ia); cfg(3'd1, ea); cfg(3'd2, n); cfg(3'd3, c); cfg(3'd4, l);
    endtask

    task automatic go();
        @(negedge clk); cfg_go = 1'b1;
        @(negedge clk); cfg_go = 1'b0;
    endtask

    task automatic request(input int hold, input logic [31:0] din);
        @(negedge clk);
        ext_din = din;
        dmar_n = 1'b0;
        repeat (hold) @(negedge clk);
        dmar_n = 1'b1;
        repeat (14 + waits) @(negedge clk);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        total++; fails++;
        $display("FAIL R2 watchdog actual=%0d expected=<%0d", WDOG, WDOG);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(dmag_n == 1'b1, "R1 grant idle", 64'(dmag_n), 64'd1);
        chk(ext_rd_n == 1'b1, "R1 read idle", 64'(ext_rd_n), 64'd1);
        chk(ext_wr_n == 1'b1, "R1 write idle", 64'(ext_wr_n), 64'd1);
        chk(irq == 1'b0, "R1 irq idle", 64'(irq), 64'd0);
        chk(mem_we == 1'b0, "R1 mem_we idle", 64'(mem_we), 64'd0);

        // R3 plain inbound, acknowledge held low must not matter; R2 long hold gives one word
        force_low = 1'b1; exp_len = 1;
        setup(16'd8, 16'd0, 16'd3, 16'd0, 16'd0);
        go();
        push(K_GIN, 16'd8,  16'd0, 32'hD000_0001, "R3 plain in w0");
        push(K_GIN, 16'd9,  16'd0, 32'hD000_0002, "R3 plain in w1");
        push(K_GIN, 16'd10, 16'd0, 32'hD000_0003, "R3 plain in w2");
        push(K_IRQ, 16'd0, 16'd0, 32'd0, "R7 irq after block");
        request(20, 32'hD000_0001);
        request(1, 32'hD000_0002);
        request(3, 32'hD000_0003);
        request(2, 32'hDEAD_0000);       // R2 idle edge must be dropped
        chk(mem[9] == 32'hD000_0002, "R3 memory holds word", 64'(mem[9]), 64'hD000_0002);

        // R3 plain outbound
        setup(16'd20, 16'd0, 16'd2, 16'd4, 16'd0);
        go();
        push(K_GOUT, 16'd20, 16'd0, mem[20], "R3 plain out w0");
        push(K_GOUT, 16'd21, 16'd0, mem[21], "R3 plain out w1");
        push(K_IRQ, 16'd0, 16'd0, 32'd0, "R7 irq plain out");
        request(2, 32'h0); request(2, 32'h0);

        // R4 and R6 external handshake with wait states
        force_low = 1'b0; waits = 2; exp_len = 3;
        setup(16'd0, 16'h0100, 16'd2, 16'd1, 16'd0);
        go();
        push(K_EWR, 16'h0100, 16'd0, 32'd0, "R4 extmem write w0");
        push(K_EWR, 16'h0101, 16'd0, 32'd0, "R4 extmem write w1");
        push(K_IRQ, 16'd0, 16'd0, 32'd0, "R7 irq extmem");
        request(2, 32'h0); request(2, 32'h0);

        waits = 0; exp_len = 1;
        setup(16'd0, 16'h0200, 16'd1, 16'd5, 16'd0);
        go();
        push(K_ERD, 16'h0200, 16'd0, 32'd0, "R4 extmem read");
        push(K_IRQ, 16'd0, 16'd0, 32'd0, "R7 irq extmem read");
        request(2, 32'h0);

        // R5 paced master inbound and outbound
        waits = 1; exp_len = 2;
        setup(16'd30, 16'h0300, 16'd2, 16'd2, 16'd0);
        go();
        push(K_PRD, 16'h0300, 16'd30, 32'hC000_0001, "R5 paced read w0");
        push(K_PRD, 16'h0301, 16'd31, 32'hC000_0002, "R5 paced read w1");
        push(K_IRQ, 16'd0, 16'd0, 32'd0, "R7 irq paced in");
        request(2, 32'hC000_0001); request(2, 32'hC000_0002);
        chk(mem[31] == 32'hC000_0002, "R5 paced word stored", 64'(mem[31]), 64'hC000_0002);

        waits = 3; exp_len = 4;
        setup(16'd8, 16'h0400, 16'd2, 16'd6, 16'd0);
        go();
        push(K_PWR, 16'h0400, 16'd8, mem[8], "R5 paced write w0");
        push(K_PWR, 16'h0401, 16'd9, mem[9], "R5 paced write w1");
        push(K_IRQ, 16'd0, 16'd0, 32'd0, "R7 irq paced out");
        request(2, 32'h0); request(2, 32'h0);

        // R9 writes while busy are ignored
        waits = 0; exp_len = 1;
        setup(16'd40, 16'd0, 16'd2, 16'd0, 16'd0);
        go();
        cfg(3'd0, 16'd50); cfg(3'd2, 16'd9);
        push(K_GIN, 16'd40, 16'd0, 32'hB000_0001, "R9 address kept w0");
        push(K_GIN, 16'd41, 16'd0, 32'hB000_0002, "R9 address kept w1");
        push(K_IRQ, 16'd0, 16'd0, 32'd0, "R9 count kept");
        request(2, 32'hB000_0001); request(2, 32'hB000_0002); request(2, 32'hB000_0003);

        // R8 chain: reserved mode value 3 acts as plain, outward
        setup(16'd4, 16'd0, 16'd1, 16'd7, 16'd56);
        go();
        push(K_GOUT, 16'd4,  16'd0, mem[4],  "R8 first block");
        push(K_GOUT, 16'd12, 16'd0, mem[12], "R8 linked w0");
        push(K_GOUT, 16'd13, 16'd0, mem[13], "R8 linked w1");
        push(K_IRQ, 16'd0, 16'd0, 32'd0, "R8 single irq at chain end");
        request(2, 32'h0); request(2, 32'h0); request(2, 32'h0); request(2, 32'h0);

        // R10 empty start
        setup(16'd0, 16'd0, 16'd0, 16'd0, 16'd0);
        push(K_IRQ, 16'd0, 16'd0, 32'd0, "R10 empty start irq");
        go();
        repeat (10) @(negedge clk);

        chk(exp_q.size() == 0, "R7 all expected events seen", 64'(exp_q.size()), 64'd0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule